// File: doc/BRIEF.md
# Reset and Halt Sequencer

This block produces the reset and halt controls for a small display-driving microcontroller core. A reset request can come from an active-high reset pin or from a power-on pulse. The two are combined, asserted at once without waiting for a clock edge, and released in step with the clock. While reset is active, the block presents the core's start-up state: the program-counter vector, the initial flag values, and the all-ones values for the I/O latches and display-mode registers. The core loads this state and begins executing once reset is released.

Two sources can halt the core. One is an active-low halt pin, which passes through a synchronizer. The other is a software halt request, which a parameter can enable or disable. A pending halt takes effect only on a cycle the core marks as an instruction boundary. The block then removes the core's clock enable, so the core's state is frozen and execution resumes from exactly that state when the halt ends. While halted, the display is blanked. A parameter chooses what the I/O does during halt: it either holds its state or goes high-impedance with the pull-ups switched off.

Top module: `rsthalt_ctrl`

## Requirements
- R1: `core_rst_o` goes high at once (without waiting for a clock edge) while `rst_pin_i` or `por_i` is high. It goes low on the second rising clock edge after both inputs are low.
- R2: `pc_vec_o` carries page 31 in its upper 5 bits and address 0x3F in its lower 6 bits, so its value is 0x7FF.
- R3: `flag_init_o` has bit 0 = instruction-interrupt request, bit 1 = timer-interrupt request, bit 2 = interrupt enable, bit 3 = carry, bit 4 = interrupt flag 0, bit 5 = interrupt flag 1, bit 6 = timer flag. Bits 0 to 3 are 0 and bits 4 to 6 are 1, so the value is 0x70.
- R4: `io_init_o` and `disp_init_o` are all ones.
- R5: `clk_en_o` is low while `core_rst_o` is high.
- R6: A low level on `halt_n_i` is seen after two clock edges. On the edge that follows a cycle with `instr_bnd_i` high and a halt pending, `halted_o` goes high and `clk_en_o` goes low.
- R7: If no software halt is pending, `halted_o` falls and `clk_en_o` returns on the third rising edge after `halt_n_i` goes high.
- R8: `lcd_blank_o` is high exactly while `halted_o` is high.
- R9: When `HALT_HIZ`=1, `io_hiz_o` is high and `pullup_en_o` is low while halted. When `HALT_HIZ`=0, `io_hiz_o` stays low and `pullup_en_o` stays high.
- R10: When `SW_HALT_EN`=1, a one-cycle pulse on `sw_halt_i` halts the core at an instruction boundary. The halt lasts until `halt_n_i` is pulsed low and then high again. When `SW_HALT_EN`=0, `sw_halt_i` has no effect.
- R11: While a halt is pending and `instr_bnd_i` stays low, `clk_en_o` stays high and `halted_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_pin_i | input | 1 | External reset, active high |
| por_i | input | 1 | Power-on reset pulse, active high |
| halt_n_i | input | 1 | External halt, active low, asynchronous |
| sw_halt_i | input | 1 | Software halt request pulse |
| instr_bnd_i | input | 1 | Core marks the last cycle of an instruction |
| core_rst_o | output | 1 | Synchronized core reset |
| pc_vec_o | output | PAGE_W+ADDR_W | Program-counter reset vector |
| flag_init_o | output | 7 | Initial flag values |
| io_init_o | output | IO_W | Initial I/O latch values |
| disp_init_o | output | 3*DISP_W | Initial display-mode register values |
| clk_en_o | output | 1 | Core clock enable |
| halted_o | output | 1 | Core is halted |
| io_hiz_o | output | 1 | Put I/O pads in high impedance |
| pullup_en_o | output | 1 | Enable I/O pull-ups |
| lcd_blank_o | output | 1 | Drive segment and common lines to one level |

## Verification
On every cycle, the assertions check four things. A halt begins only after a boundary cycle. Blanking tracks the halt state exactly. The clock enable is off while halted. High impedance appears only while halted and with the pull-ups off. They also check that reset releases only once both reset sources have been low, and that the clock enable returns as a halt ends. Other behaviour can only be shown by the bench's scenarios: the exact cycle counts of the synchronizers, the start-up vector and initial values, the two parameter variants side by side, a software halt being held until the pin is pulsed, and a software request being ignored when that option is off.

// File: rtl/rhc_pkg.sv
package rhc_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_HALTED = 2'd2
    } halt_state_e;

    typedef struct packed {
        logic tmr_flag;
        logic int_flag1;
        logic int_flag0;
        logic carry;
        logic int_en;
        logic tmr_irq;
        logic instr_irq;
    } flag_init_t;

    localparam flag_init_t FLAG_RESET = '{
        tmr_flag:  1'b1,
        int_flag1: 1'b1,
        int_flag0: 1'b1,
        carry:     1'b0,
        int_en:    1'b0,
        tmr_irq:   1'b0,
        instr_irq: 1'b0
    };

    typedef struct packed {
        halt_state_e state;
        logic        sw_pend;
        logic        pin_prev;
    } fsm_regs_t;

endpackage

// File: rtl/rhc_rst_sync.sv
module rhc_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic req_i,
    output logic rst_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], 1'b0};
        end else begin : g_single
            always_comb chain_d = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk_i or posedge req_i) begin
        if (req_i) chain_q <= '1;
        else       chain_q <= chain_d;
    end

    assign rst_o = chain_q[STAGES-1];
endmodule

// File: rtl/rhc_bit_sync.sv
module rhc_bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end else begin : g_single
            always_comb sh_d = d_i;
        end
    endgenerate

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rhc_halt_fsm.sv
module rhc_halt_fsm
    import rhc_pkg::*;
#(
    parameter bit SW_HALT_EN = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_run_i,
    input  logic sw_halt_i,
    input  logic instr_bnd_i,
    output logic halted_o
);
    fsm_regs_t regs_q;
    fsm_regs_t regs_d;
    logic      pin_rise;
    logic      halt_req;

    always_comb begin
        regs_d   = regs_q;
        pin_rise = pin_run_i & ~regs_q.pin_prev;
        halt_req = ~pin_run_i | regs_q.sw_pend;

        regs_d.pin_prev = pin_run_i;

        if (SW_HALT_EN) begin
            if (pin_rise)
                regs_d.sw_pend = 1'b0;
            else if (sw_halt_i && regs_q.state != ST_HALTED)
                regs_d.sw_pend = 1'b1;
        end else begin
            regs_d.sw_pend = 1'b0;
        end

        case (regs_q.state)
            ST_RUN: begin
                if (halt_req)
                    regs_d.state = instr_bnd_i ? ST_HALTED : ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!halt_req)
                    regs_d.state = ST_RUN;
                else if (instr_bnd_i)
                    regs_d.state = ST_HALTED;
            end
            ST_HALTED: begin
                if (!halt_req)
                    regs_d.state = ST_RUN;
            end
            default: regs_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            regs_q.state    <= ST_RUN;
            regs_q.sw_pend  <= 1'b0;
            regs_q.pin_prev <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign halted_o = (regs_q.state == ST_HALTED);
endmodule

// File: rtl/rsthalt_ctrl.sv
module rsthalt_ctrl
    import rhc_pkg::*;
#(
    parameter int PAGE_W      = 5,
    parameter int ADDR_W      = 6,
    parameter int RESET_PAGE  = 31,
    parameter int RESET_ADDR  = 63,
    parameter int IO_W        = 16,
    parameter int DISP_W      = 4,
    parameter int RST_STAGES  = 2,
    parameter int HALT_STAGES = 2,
    parameter bit SW_HALT_EN  = 1'b1,
    parameter bit HALT_HIZ    = 1'b1
) (
    input  logic                       clk_i,
    input  logic                       rst_pin_i,
    input  logic                       por_i,
    input  logic                       halt_n_i,
    input  logic                       sw_halt_i,
    input  logic                       instr_bnd_i,
    output logic                       core_rst_o,
    output logic [PAGE_W+ADDR_W-1:0]   pc_vec_o,
    output logic [6:0]                 flag_init_o,
    output logic [IO_W-1:0]            io_init_o,
    output logic [3*DISP_W-1:0]        disp_init_o,
    output logic                       clk_en_o,
    output logic                       halted_o,
    output logic                       io_hiz_o,
    output logic                       pullup_en_o,
    output logic                       lcd_blank_o
);
    localparam int DISP_TOT = 3 * DISP_W;
    localparam logic [PAGE_W-1:0] VEC_PAGE = PAGE_W'(RESET_PAGE);
    localparam logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(RESET_ADDR);

    logic rst_req;
    logic core_rst;
    logic pin_run;
    logic halted;

    assign rst_req = rst_pin_i | por_i;

    rhc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
        .clk_i (clk_i),
        .req_i (rst_req),
        .rst_o (core_rst)
    );

    rhc_bit_sync #(.STAGES(HALT_STAGES), .RST_VAL(1'b1)) u_halt_sync (
        .clk_i  (clk_i),
        .arst_i (core_rst),
        .d_i    (halt_n_i),
        .q_o    (pin_run)
    );

    rhc_halt_fsm #(.SW_HALT_EN(SW_HALT_EN)) u_fsm (
        .clk_i       (clk_i),
        .rst_i       (core_rst),
        .pin_run_i   (pin_run),
        .sw_halt_i   (sw_halt_i),
        .instr_bnd_i (instr_bnd_i),
        .halted_o    (halted)
    );

    assign core_rst_o  = core_rst;
    assign pc_vec_o    = {VEC_PAGE, VEC_ADDR};
    assign flag_init_o = FLAG_RESET;
    assign io_init_o   = '1;
    assign disp_init_o = {DISP_TOT{1'b1}};
    assign clk_en_o    = ~core_rst & ~halted;
    assign halted_o    = halted;
    assign lcd_blank_o = halted;

    generate
        if (HALT_HIZ) begin : g_hiz
            assign io_hiz_o    = halted;
            assign pullup_en_o = ~halted;
        end else begin : g_keep
            assign io_hiz_o    = 1'b0;
            assign pullup_en_o = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/rsthalt_ctrl_chk.sv
module rsthalt_ctrl_chk (
    input logic clk_i,
    input logic rst_pin_i,
    input logic por_i,
    input logic instr_bnd_i,
    input logic core_rst_o,
    input logic clk_en_o,
    input logic halted_o,
    input logic io_hiz_o,
    input logic pullup_en_o,
    input logic lcd_blank_o
);
    // R1: reset is released only after both sources were low
    p_rst_release_r1: assert property (@(posedge clk_i) disable iff (rst_pin_i || por_i)
        $fell(core_rst_o) |-> (!$past(rst_pin_i) && !$past(por_i)));

    // R11: halt only begins after a boundary cycle
    p_halt_on_bnd_r11: assert property (@(posedge clk_i) disable iff (core_rst_o)
        $rose(halted_o) |-> $past(instr_bnd_i));

    // R6: clock enable off while halted
    p_clk_off_r6: assert property (@(posedge clk_i) disable iff (core_rst_o)
        halted_o |-> !clk_en_o);

    // R7: clock enable returns when halt ends
    p_resume_r7: assert property (@(posedge clk_i) disable iff (core_rst_o)
        $fell(halted_o) |-> clk_en_o);

    // R8: blanking follows halt
    p_blank_r8: assert property (@(posedge clk_i) disable iff (core_rst_o)
        lcd_blank_o == halted_o);

    // R9: high impedance only while halted with pull-ups off
    p_hiz_r9: assert property (@(posedge clk_i) disable iff (core_rst_o)
        io_hiz_o |-> (halted_o && !pullup_en_o));
endmodule

bind rsthalt_ctrl rsthalt_ctrl_chk u_chk (
    .clk_i       (clk_i),
    .rst_pin_i   (rst_pin_i),
    .por_i       (por_i),
    .instr_bnd_i (instr_bnd_i),
    .core_rst_o  (core_rst_o),
    .clk_en_o    (clk_en_o),
    .halted_o    (halted_o),
    .io_hiz_o    (io_hiz_o),
    .pullup_en_o (pullup_en_o),
    .lcd_blank_o (lcd_blank_o)
);

// File: tb/test_rsthalt_ctrl.sv
module test_rsthalt_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_pin, por, halt_n, sw_halt, bnd;

    logic        rst_a, clk_en_a, halted_a, hiz_a, pu_a, blank_a;
    logic [10:0] pc_a;
    logic [6:0]  flags_a;
    logic [15:0] io_a;
    logic [11:0] disp_a;

    logic        rst_b, clk_en_b, halted_b, hiz_b, pu_b, blank_b;
    logic [10:0] pc_b;
    logic [6:0]  flags_b;
    logic [15:0] io_b;
    logic [11:0] disp_b;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsthalt_ctrl i_rsthalt_ctrl (
        .clk_i(clk), .rst_pin_i(rst_pin), .por_i(por), .halt_n_i(halt_n),
        .sw_halt_i(sw_halt), .instr_bnd_i(bnd), .core_rst_o(rst_a),
        .pc_vec_o(pc_a), .flag_init_o(flags_a), .io_init_o(io_a),
        .disp_init_o(disp_a), .clk_en_o(clk_en_a), .halted_o(halted_a),
        .io_hiz_o(hiz_a), .pullup_en_o(pu_a), .lcd_blank_o(blank_a)
    );

    rsthalt_ctrl #(.SW_HALT_EN(1'b0), .HALT_HIZ(1'b0)) i_rsthalt_ctrl_keep (
        .clk_i(clk), .rst_pin_i(rst_pin), .por_i(por), .halt_n_i(halt_n),
        .sw_halt_i(sw_halt), .instr_bnd_i(bnd), .core_rst_o(rst_b),
        .pc_vec_o(pc_b), .flag_init_o(flags_b), .io_init_o(io_b),
        .disp_init_o(disp_b), .clk_en_o(clk_en_b), .halted_o(halted_b),
        .io_hiz_o(hiz_b), .pullup_en_o(pu_b), .lcd_blank_o(blank_b)
    );

    function automatic logic [10:0] exp_vec();
        return {5'd31, 6'h3F};
    endfunction

    function automatic logic [6:0] exp_flags();
        return 7'b111_0000;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        rst_pin = 1'b1; por = 1'b0; halt_n = 1'b1; sw_halt = 1'b0; bnd = 1'b0;
        tick(3);
        // R1 R5: reset state
        check("R1 reset active", rst_a, 1);
        check("R5 clk_en in reset", clk_en_a, 0);
        rst_pin = 1'b0;
        tick(1);
        check("R1 still in reset after one edge", rst_a, 1);
        tick(1);
        check("R1 released after two edges", rst_a, 0);
        check("R5 clk_en after release", clk_en_a, 1);
        check("R2 pc vector", pc_a, exp_vec());
        check("R3 flag init", flags_a, exp_flags());
        check("R4 io init", io_a, 16'hFFFF);
        check("R4 disp init", disp_a, 12'hFFF);
        check("R2 pc vector keep", pc_b, exp_vec());

        // R1: power-on pulse asserts at once
        por = 1'b1;
        #1;
        check("R1 async assert on por", rst_a, 1);
        @(negedge clk);
        por = 1'b0;
        tick(2);
        check("R1 release after por", rst_a, 0);

        // R11: pending halt without boundary
        halt_n = 1'b0;
        bnd = 1'b0;
        tick(6);
        check("R11 no halt without boundary", halted_a, 0);
        check("R11 clk_en held", clk_en_a, 1);
        bnd = 1'b1;
        tick(1);
        check("R6 halted at boundary", halted_a, 1);
        check("R6 clk_en off", clk_en_a, 0);
        check("R8 blank on", blank_a, 1);
        check("R9 hiz on", hiz_a, 1);
        check("R9 pullups off", pu_a, 0);
        check("R9 keep variant hiz", hiz_b, 0);
        check("R9 keep variant pullups", pu_b, 1);
        check("R8 keep variant blank", blank_b, 1);

        // R7: release timing
        halt_n = 1'b1;
        tick(2);
        check("R7 still halted after two edges", halted_a, 1);
        tick(1);
        check("R7 resumed after third edge", halted_a, 0);
        check("R7 clk_en back", clk_en_a, 1);
        check("R8 blank off", blank_a, 0);
        check("R9 hiz off", hiz_a, 0);

        // R10: software halt
        sw_halt = 1'b1;
        tick(1);
        sw_halt = 1'b0;
        tick(3);
        check("R10 sw halt taken", halted_a, 1);
        check("R10 sw halt ignored when disabled", halted_b, 0);
        check("R10 ignored variant clk_en", clk_en_b, 1);
        tick(5);
        check("R10 sw halt held", halted_a, 1);
        halt_n = 1'b0;
        tick(1);
        halt_n = 1'b1;
        tick(8);
        check("R10 wake by pin pulse", halted_a, 0);
        check("R10 wake clk_en", clk_en_a, 1);

        // R1: reset during halt
        halt_n = 1'b0;
        tick(4);
        check("R6 halted before reset", halted_a, 1);
        rst_pin = 1'b1;
        #1;
        check("R1 reset clears halt", halted_a, 0);
        check("R5 clk_en in reset", clk_en_a, 0);
        halt_n = 1'b1;
        @(negedge clk);
        rst_pin = 1'b0;
        tick(4);

        // Random: halt entry only after a boundary
        void'($urandom(32'h1234));
        for (int t = 0; t < 40; t++) begin
            automatic logic prev_bnd = 1'b0;
            automatic int seen = 0;
            bnd = 1'b0;
            halt_n = 1'b0;
            tick(2);
            for (int c = 0; c < 30 && seen == 0; c++) begin
                bnd = (c == 20) ? 1'b1 : 1'($urandom_range(0, 3) == 0);
                prev_bnd = bnd;
                tick(1);
                if (halted_a) begin
                    seen = 1;
                    check("R6 halt follows boundary", prev_bnd, 1);
                end
            end
            check("R6 random halt reached", seen, 1);
            check("R8 random blank", blank_a, halted_a);
            halt_n = 1'b1;
            tick(3 + int'($urandom_range(0, 2)));
            check("R7 random resume", clk_en_a, 1);
        end

        finish_run();
    end
endmodule